// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

The block is a watchdog timer that runs from its own watchdog clock and is set up over a small register bus clocked separately. Software starts the watchdog with a start key. After that it must keep writing a refresh key to the key register before a 12-bit down-counter runs out. If the counter runs out, the block raises a one-cycle reset request in the watchdog clock domain and reloads the counter. The counter steps once per tick of a prescaler, and the prescaler divides the watchdog clock by a power of two from 4 to 256.

The prescaler select and the reload value are write-protected. A write to either one is accepted only after the unlock key has been written, and only while no earlier write to that register is still crossing into the watchdog domain. Each accepted write goes through a toggle handshake. A busy flag for that register stays set until the watchdog domain holds the new value. A read of either register returns the value held in the watchdog domain.

Control state machines: the lock machine has states `LK_LOCKED` and `LK_OPEN`. An unlock key moves it from LOCKED to OPEN, and any other key value moves it back to LOCKED. Each update channel has states `UPD_IDLE` and `UPD_WAIT`. An accepted write moves it from IDLE to WAIT, and the returning acknowledge moves it from WAIT to IDLE. The watchdog machine has states `WD_IDLE` and `WD_COUNT`. The start key moves it from IDLE to COUNT, and it never leaves COUNT.

Top module: `wdt_top`

## Requirements
- R1: After reset, the prescaler register (address 1) reads 0, the reload register (address 2) reads 0xFFF, the status register (address 3) reads 0, and wd_rst_req is low.
- R2: A write to address 1 or 2 is accepted only when the last value written to the key register (address 0) was 0x5555. Writing any other key value locks the registers again. A refused write changes neither the register value nor the busy flags.
- R3: Status bit 0 is the prescaler busy flag and bit 1 is the reload busy flag. The flag is set in the bus cycle after an accepted write and clears once the watchdog domain holds the new value. A read of address 1 or 2 then returns that value.
- R4: A write to a register whose busy flag is set is refused, and the value in flight is the one that lands.
- R5: Until the key 0xCCCC is written, the watchdog is idle and never asserts wd_rst_req.
- R6: Once started, the watchdog keeps running whatever key values are written afterwards.
- R7: With no refresh, reset requests are spaced exactly (reload + 1) × divider watchdog clock cycles apart, and each request is high for exactly one watchdog cycle.
- R8: Prescaler codes 0 to 5 divide by 4 << code (4, 8, 16, 32, 64, 128). Codes 6 and 7 both divide by 256.
- R9: Writing the key 0xAAAA reloads the counter and restarts the prescaler. Refreshing more often than the timeout period prevents any reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational; key reads 0) |
| wd_clk | input | 1 | Watchdog clock |
| wd_rst_n | input | 1 | Active-low asynchronous reset, watchdog domain |
| wd_rst_req | output | 1 | One-cycle reset request on timeout, watchdog domain |

## Verification
Timeout periods are measured between consecutive reset requests. The settings tried are reload 9 at /4, reload 3 at /8, and reload 0 at /128 and at /256 for both code 6 and code 7. Together these separate an off-by-one in the reload count from an error in the divider decode, and they show whether the two top codes really share one divider. Configuration writes are tried in four conditions: while locked, after a relocking key, back to back while busy, and after a proper unlock. This tells a refused write apart from a lost or late one. A burst of refreshes followed by silence separates a refresh that has no effect from a watchdog that never fires. Keys written after start check that the watchdog cannot be stopped.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_PSC  = 2'd1;
    localparam logic [1:0] ADDR_RLD  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef enum logic {LK_LOCKED, LK_OPEN} lock_state_e;
    typedef enum logic {UPD_IDLE, UPD_WAIT} upd_state_e;
    typedef enum logic {WD_IDLE, WD_COUNT} wd_state_e;
endpackage

// File: rtl/wdt_toggle_sync.sv
module wdt_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic dst_clk,
    input  logic dst_rst_n,
    input  logic tgl_in,
    output logic lvl_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], tgl_in};
        end
    end

    assign lvl_out = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_update_chan.sv
module wdt_update_chan #(
    parameter int          W       = 12,
    parameter logic [W-1:0] RST_VAL = '1,
    parameter int          STAGES  = 2
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         accept,
    input  logic [W-1:0] wdata,
    output logic         busy,
    input  logic         wd_clk,
    input  logic         wd_rst_n,
    output logic [W-1:0] wd_val
);
    import wdt_pkg::*;

    upd_state_e   state_q, state_d;
    logic [W-1:0] hold_q;
    logic         req_q;
    logic         ack_sync;
    logic         req_sync;
    logic         ack_q;

    // bus side: state register
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            state_q <= UPD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE: if (accept)             state_d = UPD_WAIT;
            UPD_WAIT: if (ack_sync == req_q)  state_d = UPD_IDLE;
        endcase
    end

    // bus side: data held stable while the request is in flight
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            hold_q <= RST_VAL;
            req_q  <= 1'b0;
        end else if (state_q == UPD_IDLE && accept) begin
            hold_q <= wdata;
            req_q  <= ~req_q;
        end
    end

    assign busy = (state_q == UPD_WAIT);

    wdt_toggle_sync #(.STAGES(STAGES)) u_req_sync (
        .dst_clk  (wd_clk),
        .dst_rst_n(wd_rst_n),
        .tgl_in   (req_q),
        .lvl_out  (req_sync)
    );

    // watchdog side: capture on request edge, echo level as acknowledge
    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) begin
            wd_val <= RST_VAL;
            ack_q  <= 1'b0;
        end else if (req_sync != ack_q) begin
            wd_val <= hold_q;
            ack_q  <= req_sync;
        end
    end

    wdt_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
        .dst_clk  (bus_clk),
        .dst_rst_n(bus_rst_n),
        .tgl_in   (ack_q),
        .lvl_out  (ack_sync)
    );
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs #(
    parameter int PSC_W = 3,
    parameter int CNT_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [1:0]                 addr,
    input  logic [wdt_pkg::DATA_W-1:0] wdata,
    input  logic                       psc_busy,
    input  logic                       rld_busy,
    input  logic [PSC_W-1:0]           psc_val,
    input  logic [CNT_W-1:0]           rld_val,
    output logic                       psc_accept,
    output logic                       rld_accept,
    output logic                       refresh_tgl,
    output logic                       start_tgl,
    output logic                       unlocked,
    output logic [wdt_pkg::DATA_W-1:0] rdata
);
    import wdt_pkg::*;

    lock_state_e lock_q, lock_d;
    logic        key_wr;

    assign key_wr = wr && (addr == ADDR_KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= LK_LOCKED;
        end else begin
            lock_q <= lock_d;
        end
    end

    always_comb begin
        lock_d = lock_q;
        unique case (lock_q)
            LK_LOCKED: if (key_wr && wdata == KEY_UNLOCK) lock_d = LK_OPEN;
            LK_OPEN:   if (key_wr && wdata != KEY_UNLOCK) lock_d = LK_LOCKED;
        endcase
    end

    assign unlocked   = (lock_q == LK_OPEN);
    assign psc_accept = wr && (addr == ADDR_PSC) && unlocked && !psc_busy;
    assign rld_accept = wr && (addr == ADDR_RLD) && unlocked && !rld_busy;

    // command toggles carried to the watchdog domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refresh_tgl <= 1'b0;
            start_tgl   <= 1'b0;
        end else if (key_wr) begin
            if (wdata == KEY_REFRESH) refresh_tgl <= ~refresh_tgl;
            if (wdata == KEY_START)   start_tgl   <= ~start_tgl;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_KEY:  rdata = '0;
            ADDR_PSC:  rdata[PSC_W-1:0] = psc_val;
            ADDR_RLD:  rdata[CNT_W-1:0] = rld_val;
            ADDR_STAT: rdata[1:0] = {rld_busy, psc_busy};
        endcase
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PSC_W    = 3,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int SPAN = MAX_LOG2 - MIN_LOG2;

    logic [MAX_LOG2-1:0] cnt_q;
    logic [MAX_LOG2-1:0] last;
    logic [PSC_W-1:0]    eff;

    always_comb begin
        eff  = (int'(sel) > SPAN) ? PSC_W'(SPAN) : sel;
        last = MAX_LOG2'((1 << (MIN_LOG2 + int'(eff))) - 1);
    end

    assign tick = run && !clear && (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear || cnt_q >= last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_counter_fsm.sv
module wdt_counter_fsm #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_p,
    input  logic             refresh_p,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             presc_clear,
    output logic             rst_req
);
    import wdt_pkg::*;

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:  if (start_p) state_d = WD_COUNT;
            WD_COUNT: state_d = WD_COUNT;
        endcase
    end

    assign running     = (state_q == WD_COUNT);
    assign presc_clear = refresh_p || !running;
    assign expire      = running && tick && (cnt_q == '0) && !refresh_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (!running || refresh_p || expire) begin
            cnt_q <= reload;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire;
        end
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int PSC_W    = 3,
    parameter int CNT_W    = 12,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 8,
    parameter int STAGES   = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        wd_clk,
    input  logic        wd_rst_n,
    output logic        wd_rst_req
);
    logic             psc_accept, rld_accept;
    logic             psc_busy, rld_busy;
    logic [PSC_W-1:0] psc_wd;
    logic [CNT_W-1:0] rld_wd;
    logic             refresh_tgl, start_tgl;
    logic             refresh_lvl, start_lvl;
    logic             refresh_last, start_last;
    logic             refresh_p, start_p;
    logic             unlocked;
    logic             wd_running;
    logic             presc_clear, tick;

    wdt_bus_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .psc_busy   (psc_busy),
        .rld_busy   (rld_busy),
        .psc_val    (psc_wd),
        .rld_val    (rld_wd),
        .psc_accept (psc_accept),
        .rld_accept (rld_accept),
        .refresh_tgl(refresh_tgl),
        .start_tgl  (start_tgl),
        .unlocked   (unlocked),
        .rdata      (bus_rdata)
    );

    wdt_update_chan #(.W(PSC_W), .RST_VAL('0), .STAGES(STAGES)) u_psc_chan (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .accept   (psc_accept),
        .wdata    (bus_wdata[PSC_W-1:0]),
        .busy     (psc_busy),
        .wd_clk   (wd_clk),
        .wd_rst_n (wd_rst_n),
        .wd_val   (psc_wd)
    );

    wdt_update_chan #(.W(CNT_W), .RST_VAL('1), .STAGES(STAGES)) u_rld_chan (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .accept   (rld_accept),
        .wdata    (bus_wdata[CNT_W-1:0]),
        .busy     (rld_busy),
        .wd_clk   (wd_clk),
        .wd_rst_n (wd_rst_n),
        .wd_val   (rld_wd)
    );

    wdt_toggle_sync #(.STAGES(STAGES)) u_refresh_sync (
        .dst_clk  (wd_clk),
        .dst_rst_n(wd_rst_n),
        .tgl_in   (refresh_tgl),
        .lvl_out  (refresh_lvl)
    );

    wdt_toggle_sync #(.STAGES(STAGES)) u_start_sync (
        .dst_clk  (wd_clk),
        .dst_rst_n(wd_rst_n),
        .tgl_in   (start_tgl),
        .lvl_out  (start_lvl)
    );

    always_ff @(posedge wd_clk or negedge wd_rst_n) begin
        if (!wd_rst_n) begin
            refresh_last <= 1'b0;
            start_last   <= 1'b0;
        end else begin
            refresh_last <= refresh_lvl;
            start_last   <= start_lvl;
        end
    end

    assign refresh_p = refresh_lvl ^ refresh_last;
    assign start_p   = start_lvl ^ start_last;

    wdt_prescaler #(.PSC_W(PSC_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_presc (
        .clk  (wd_clk),
        .rst_n(wd_rst_n),
        .run  (wd_running),
        .clear(presc_clear),
        .sel  (psc_wd),
        .tick (tick)
    );

    wdt_counter_fsm #(.CNT_W(CNT_W)) u_core (
        .clk        (wd_clk),
        .rst_n      (wd_rst_n),
        .start_p    (start_p),
        .refresh_p  (refresh_p),
        .tick       (tick),
        .reload     (rld_wd),
        .running    (wd_running),
        .presc_clear(presc_clear),
        .rst_req    (wd_rst_req)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic        bus_clk,
    input logic        bus_rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        wd_clk,
    input logic        wd_rst_n,
    input logic        wd_rst_req,
    input logic        unlocked,
    input logic        psc_busy,
    input logic        rld_busy,
    input logic        wd_running
);
    import wdt_pkg::*;

    a_r7_single_pulse: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        wd_rst_req |=> !wd_rst_req);

    a_r5_idle_quiet: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        !wd_running |-> !wd_rst_req);

    a_r6_run_sticky: assert property (@(posedge wd_clk) disable iff (!wd_rst_n)
        wd_running |=> wd_running);

    a_r2_relock: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && bus_addr == ADDR_KEY && bus_wdata != KEY_UNLOCK) |=> !unlocked);

    a_r2_psc_gate: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(psc_busy) |-> $past(unlocked && bus_wr && bus_addr == ADDR_PSC));

    a_r2_rld_gate: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(rld_busy) |-> $past(unlocked && bus_wr && bus_addr == ADDR_RLD));

    a_r3_busy_on_accept: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (unlocked && bus_wr && bus_addr == ADDR_RLD) |=> rld_busy);
endmodule

bind wdt_top wdt_checker u_chk (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wd_clk    (wd_clk),
    .wd_rst_n  (wd_rst_n),
    .wd_rst_req(wd_rst_req),
    .unlocked  (unlocked),
    .psc_busy  (psc_busy),
    .rld_busy  (rld_busy),
    .wd_running(wd_running)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
    logic        bus_clk = 1'b0;
    logic        wd_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        wd_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wd_rst_req;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 bus_clk = ~bus_clk;
    always #8 wd_clk = ~wd_clk;

    wdt_top dut (
        .bus_clk   (bus_clk),
        .bus_rst_n (bus_rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wd_clk    (wd_clk),
        .wd_rst_n  (wd_rst_n),
        .wd_rst_req(wd_rst_req)
    );

    always @(negedge wd_clk) if (wd_rst_req) pulses++;

    task automatic check_eq(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output int d);
        @(negedge bus_clk);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic wait_idle();
        int s;
        for (int i = 0; i < 200; i++) begin
            bus_read(2'd3, s);
            if (s == 0) break;
        end
    endtask

    // period in wd cycles between two reset requests; also width of first
    task automatic measure(output int period, output int width_ok);
        int g = 0;
        period = 0;
        width_ok = 1;
        do begin @(negedge wd_clk); g++; end while (!wd_rst_req && g < 20000);
        do begin
            @(negedge wd_clk);
            period++;
            if (period == 1 && wd_rst_req) width_ok = 0;
        end while (!wd_rst_req && period < 20000);
    endtask

    task automatic t_reset();
        int v;
        bus_read(2'd1, v); check_eq("R1 prescaler reset", v, 0);
        bus_read(2'd2, v); check_eq("R1 reload reset", v, 12'hFFF);
        bus_read(2'd3, v); check_eq("R1 status reset", v, 0);
        repeat (600) @(negedge wd_clk);
        check_eq("R1 R5 no request before start", pulses, 0);
    endtask

    task automatic t_lock();
        int v;
        bus_write(2'd1, 16'h3);
        bus_read(2'd3, v); check_eq("R2 locked write no busy", v, 0);
        repeat (20) @(negedge bus_clk);
        bus_read(2'd1, v); check_eq("R2 locked write ignored", v, 0);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'h0);
        bus_write(2'd2, 16'd20);
        bus_read(2'd3, v); check_eq("R3 both busy after writes", v, 3);
        wait_idle();
        bus_read(2'd2, v); check_eq("R3 reload landed", v, 20);
        bus_write(2'd0, 16'h1234);
        bus_write(2'd2, 16'd40);
        bus_read(2'd3, v); check_eq("R2 relocked no busy", v, 0);
        repeat (20) @(negedge bus_clk);
        bus_read(2'd2, v); check_eq("R2 relocked write ignored", v, 20);
    endtask

    task automatic t_busy_refuse();
        int v;
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'd9);
        bus_write(2'd2, 16'd30);
        wait_idle();
        bus_read(2'd2, v); check_eq("R4 second write refused", v, 9);
        bus_read(2'd3, v); check_eq("R3 busy cleared", v, 0);
    endtask

    task automatic t_start_period();
        int p, w;
        bus_write(2'd0, 16'hCCCC);
        measure(p, w);
        check_eq("R7 period reload 9 div 4", p, 40);
        check_eq("R7 one-cycle request", w, 1);
    endtask

    task automatic t_refresh();
        int p0;
        int g = 0;
        while (!wd_rst_req && g < 2000) begin @(negedge wd_clk); g++; end
        bus_write(2'd0, 16'hAAAA);
        repeat (10) @(negedge bus_clk);
        p0 = pulses;
        for (int i = 0; i < 40; i++) begin
            bus_write(2'd0, 16'hAAAA);
            repeat (10) @(negedge bus_clk);
        end
        check_eq("R9 refresh suppresses requests", pulses - p0, 0);
        repeat (100) @(negedge wd_clk);
        check_eq("R9 request after refresh stops", int'(pulses > p0), 1);
    endtask

    task automatic t_div(input int code, input int rld, input int exp);
        int p, w;
        bus_write(2'd0, 16'h5555);
        bus_write(2'd1, 16'(code));
        bus_write(2'd2, 16'(rld));
        wait_idle();
        measure(p, w);
        measure(p, w);
        check_eq($sformatf("R8 R7 period code %0d reload %0d", code, rld), p, exp);
    endtask

    task automatic t_no_stop();
        int p, w;
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'hFFFF);
        measure(p, w);
        measure(p, w);
        check_eq("R6 still running after other keys", p, 32);
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge bus_clk);
        bus_rst_n = 1'b1;
        @(negedge wd_clk);
        wd_rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        t_reset();
        t_lock();
        t_busy_refuse();
        t_start_period();
        t_refresh();
        t_div(5, 0, 128);
        t_div(6, 0, 256);
        t_div(7, 0, 256);
        t_div(1, 3, 32);
        t_no_stop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule